// File: doc/BRIEF.md
# Bus Tenure Request Controller

This block decides when a bus initiator asks for the shared bus, when its ownership actually begins, and when it lets go of the request. An internal DMA engine raises a level need. The controller answers by driving an active-low request to the central arbiter. It then watches the active-low grant together with the bus FRAME# and IRDY# lines. Only once grant is held and the bus has been seen idle does it hand a one-cycle start pulse to the transaction sequencer.

The sequencer reports back three things while it owns the bus. It flags each FRAME# assertion, and says with that flag whether this is the final transaction of the tenure. It flags the start of the last data phase. It flags the end of the final transaction. The request is released by one of two policies. Early release drops it in the very clock that FRAME# goes low for the final transaction. Extended release applies to burst tenures only and keeps it until the last data phase starts.

Once raised, the request ignores stop and suspend and waits for the grant. Only a hardware or software reset removes it at once. When the tenure ends, a done pulse goes back to the DMA engine. The engine may then raise a fresh need.

Top module: `pci_tenure_ctrl`

## Requirements
- R1: In the idle state, a high `dma_need` with `stop_req` and `suspend_req` both low drives `req_n` low after the next rising edge; if either stop or suspend is high, `req_n` stays high.
- R2: `seq_start` pulses high for exactly one clock, after the rising edge at which `gnt_n` is sampled low while the registered idle flag is set; that flag is captured one edge earlier from `frame_n` and `irdy_n` both high.
- R3: If `gnt_n` returns high before the start condition is met, no `seq_start` occurs, and `req_n` stays low until grant comes back together with an idle bus.
- R4: Once `req_n` is low, `stop_req` and `suspend_req` have no effect on it until ownership begins.
- R5: With early release (non-burst, or burst with `ext_hold` low), `req_n` goes high combinationally in the clock where `seq_frame` is high and the transaction is final (`seq_final` high, or any transaction in burst mode).
- R6: In non-burst mode, a `seq_frame` with `seq_final` low leaves `req_n` low.
- R7: With `burst_mode` and `ext_hold` both high, `seq_frame` leaves `req_n` low, and `req_n` goes high combinationally in the clock where `seq_last_data` is high.
- R8: At most one `seq_start` is issued per tenure, even while grant and an idle bus persist.
- R9: `seq_end` during ownership produces a one-clock `dma_done` pulse after the next rising edge, and the block returns to idle.
- R10: `soft_rst` high forces `req_n` high in the same clock and clears the tenure state at the next edge; `rst_n` low forces `req_n` high asynchronously.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, all inputs sampled on its rising edge |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| soft_rst | input | 1 | Synchronous software reset, active high, gates the request at once |
| dma_need | input | 1 | Level need for the bus from the DMA engine |
| stop_req | input | 1 | Stop request; blocks only a request not yet raised |
| suspend_req | input | 1 | Suspend request; blocks only a request not yet raised |
| burst_mode | input | 1 | 1: this tenure is one burst transaction |
| ext_hold | input | 1 | 1: extended release in burst mode |
| gnt_n | input | 1 | Arbiter grant, active low |
| frame_n | input | 1 | Bus FRAME#, active low |
| irdy_n | input | 1 | Bus IRDY#, active low |
| seq_frame | input | 1 | Sequencer is asserting FRAME# for a transaction this clock |
| seq_final | input | 1 | Qualifies seq_frame: this is the last transaction of the tenure |
| seq_last_data | input | 1 | Sequencer begins the last data phase this clock |
| seq_end | input | 1 | Final transaction of the tenure has completed |
| req_n | output | 1 | Bus request to the arbiter, active low |
| seq_start | output | 1 | One-clock pulse telling the sequencer to begin its address phase |
| dma_done | output | 1 | One-clock pulse telling the DMA engine the tenure is over |

## Verification
The assertions take the sequencer indications as trustworthy. They assume `seq_frame`, `seq_last_data` and `seq_end` arrive only after `seq_start`, and that `burst_mode` and `ext_hold` stay steady across a tenure. The stimulus drives the sequencer flags only once the start pulse has been observed. It changes configuration only while the block is idle, and drops `dma_need` together with `seq_end`, so no tenure overlaps another. Both resets are applied mid-tenure, and the disable condition covers them.

// File: rtl/tenure_pkg.sv
package tenure_pkg;
  typedef enum logic [1:0] {
    TS_IDLE = 2'd0,
    TS_ARB  = 2'd1,
    TS_OWN  = 2'd2
  } tenure_state_t;
endpackage

// File: rtl/bus_idle_sense.sv
module bus_idle_sense #(
  parameter int STAGES = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_n,
  input  logic irdy_n,
  output logic idle_q
);
  logic [STAGES-1:0] pipe;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[i] <= 1'b0;
        else if (i == 0) pipe[i] <= frame_n & irdy_n;
        else pipe[i] <= pipe[(i > 0) ? i-1 : 0] & frame_n & irdy_n;
      end
    end
  endgenerate

  assign idle_q = pipe[STAGES-1];

  assert_idle_src_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (STAGES == 1 && idle_q) |-> $past(frame_n & irdy_n));
endmodule

// File: rtl/tenure_fsm.sv
module tenure_fsm
  import tenure_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic soft_rst,
  input  logic dma_need,
  input  logic stop_req,
  input  logic suspend_req,
  input  logic gnt_n,
  input  logic idle_q,
  input  logic seq_end,
  output logic raise,
  output logic owning,
  output logic start_q,
  output logic done_q
);
  tenure_state_t state;
  logic          start_cond;

  assign raise      = (state == TS_IDLE) && dma_need && !stop_req && !suspend_req;
  assign start_cond = (state == TS_ARB) && !gnt_n && idle_q;
  assign owning     = (state == TS_OWN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= TS_IDLE;
      start_q <= 1'b0;
      done_q  <= 1'b0;
    end else if (soft_rst) begin
      state   <= TS_IDLE;
      start_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      start_q <= start_cond;
      done_q  <= owning && seq_end;
      unique case (state)
        TS_IDLE: if (raise) state <= TS_ARB;
        TS_ARB:  if (start_cond) state <= TS_OWN;
        TS_OWN:  if (seq_end) state <= TS_IDLE;
        default: state <= TS_IDLE;
      endcase
    end
  end

  assert_single_start_R8: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    start_q |=> !start_q);
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    done_q |=> !done_q);
  assert_start_owns_R2: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    start_q |-> owning);
endmodule

// File: rtl/req_driver.sv
module req_driver (
  input  logic clk,
  input  logic rst_n,
  input  logic soft_rst,
  input  logic raise,
  input  logic drop_now,
  input  logic clear,
  input  logic owning,
  output logic req_n
);
  logic req_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else if (soft_rst) req_q <= 1'b0;
    else if (raise) req_q <= 1'b1;
    else if (drop_now || clear) req_q <= 1'b0;
  end

  assign req_n = !(req_q && !drop_now && !soft_rst);

  assert_hold_until_grant_R4: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    (req_q && !owning) |=> req_q);

  always_comb begin
    if (rst_n && soft_rst) assert_soft_release_R10: assert (req_n);
  end
endmodule

// File: rtl/pci_tenure_ctrl.sv
module pci_tenure_ctrl #(
  parameter int IDLE_STAGES = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic soft_rst,
  input  logic dma_need,
  input  logic stop_req,
  input  logic suspend_req,
  input  logic burst_mode,
  input  logic ext_hold,
  input  logic gnt_n,
  input  logic frame_n,
  input  logic irdy_n,
  input  logic seq_frame,
  input  logic seq_final,
  input  logic seq_last_data,
  input  logic seq_end,
  output logic req_n,
  output logic seq_start,
  output logic dma_done
);
  logic idle_q, raise, owning, drop_now, extended, final_frame;

  bus_idle_sense #(.STAGES(IDLE_STAGES)) i_idle (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n), .idle_q(idle_q)
  );

  tenure_fsm i_fsm (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .dma_need(dma_need),
    .stop_req(stop_req), .suspend_req(suspend_req), .gnt_n(gnt_n), .idle_q(idle_q),
    .seq_end(seq_end), .raise(raise), .owning(owning), .start_q(seq_start), .done_q(dma_done)
  );

  assign extended    = burst_mode && ext_hold;
  assign final_frame = seq_frame && (burst_mode || seq_final);
  assign drop_now    = owning && (extended ? seq_last_data : final_frame);

  req_driver i_req (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .raise(raise), .drop_now(drop_now),
    .clear(owning && seq_end), .owning(owning), .req_n(req_n)
  );

  assert_early_release_R5: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    (owning && !extended && final_frame) |-> req_n);
  assert_ext_release_R7: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    (owning && extended && seq_last_data) |-> req_n);
  assert_start_needs_grant_R3: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    $rose(seq_start) |-> $past(!gnt_n));
endmodule

// File: tb/test_pci_tenure_ctrl.sv
module test_pci_tenure_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0, soft_rst = 1'b0, dma_need = 1'b0, stop_req = 1'b0, suspend_req = 1'b0;
  logic burst_mode = 1'b0, ext_hold = 1'b0, gnt_n = 1'b1, frame_n = 1'b1, irdy_n = 1'b1;
  logic seq_frame = 1'b0, seq_final = 1'b0, seq_last_data = 1'b0, seq_end = 1'b0;
  logic req_n, seq_start, dma_done;
  int checks = 0, failures = 0, cyc = 0;

  always #10 clk = ~clk;

  pci_tenure_ctrl i_pci_tenure_ctrl (.*);

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic nclk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_tenure();
    seq_end = 1'b1; dma_need = 1'b0; gnt_n = 1'b1;
    nclk(1); seq_end = 1'b0;
    chk("R9 done pulse", dma_done, 1'b1);
    nclk(1);
    chk("R9 done one clock", dma_done, 1'b0);
  endtask

  task automatic get_bus(input logic burst, input logic ext);
    burst_mode = burst; ext_hold = ext;
    dma_need = 1'b1; nclk(1);
    chk("R1 request raised", req_n, 1'b0);
    gnt_n = 1'b0; nclk(1);
    chk("R2 start pulse", seq_start, 1'b1);
    nclk(1);
    chk("R2 start one clock", seq_start, 1'b0);
  endtask

  task automatic t_reset();
    nclk(2);
    chk("R10 reset req_n", req_n, 1'b1);
    chk("R10 reset start", seq_start, 1'b0);
    chk("R10 reset done", dma_done, 1'b0);
    rst_n = 1'b1; nclk(2);
  endtask

  task automatic t_block_and_hold();
    stop_req = 1'b1; dma_need = 1'b1; nclk(2);
    chk("R1 stop blocks raise", req_n, 1'b1);
    stop_req = 1'b0; suspend_req = 1'b1; nclk(2);
    chk("R1 suspend blocks raise", req_n, 1'b1);
    suspend_req = 1'b0; nclk(1);
    chk("R1 raise after release", req_n, 1'b0);
    stop_req = 1'b1; suspend_req = 1'b1; nclk(3);
    chk("R4 held against stop/suspend", req_n, 1'b0);
    stop_req = 1'b0; suspend_req = 1'b0;
    gnt_n = 1'b0; nclk(1);
    chk("R4 start after hold", seq_start, 1'b1);
    nclk(1);
    seq_frame = 1'b1; seq_final = 1'b1; #1;
    chk("R5 nonburst final frame drops", req_n, 1'b1);
    nclk(1); seq_frame = 1'b0; seq_final = 1'b0;
    finish_tenure();
  endtask

  task automatic t_grant_withdraw();
    frame_n = 1'b0; dma_need = 1'b1; nclk(1);
    chk("R3 requested while busy", req_n, 1'b0);
    gnt_n = 1'b0; nclk(1);
    chk("R3 no start on busy bus", seq_start, 1'b0);
    gnt_n = 1'b1; frame_n = 1'b1; nclk(1);
    chk("R3 no start grant gone", seq_start, 1'b0);
    nclk(1);
    chk("R3 still no start", seq_start, 1'b0);
    chk("R3 request held", req_n, 1'b0);
    gnt_n = 1'b0; nclk(1);
    chk("R2 start on regrant idle", seq_start, 1'b1);
    nclk(2);
    chk("R8 no second start", seq_start, 1'b0);
    seq_frame = 1'b1; seq_final = 1'b1; #1;
    chk("R5 drop on final frame", req_n, 1'b1);
    nclk(1); seq_frame = 1'b0; seq_final = 1'b0;
    finish_tenure();
  endtask

  task automatic t_nonburst_multi();
    get_bus(1'b0, 1'b1);
    seq_frame = 1'b1; #1;
    chk("R6 nonfinal frame keeps req", req_n, 1'b0);
    nclk(1); seq_frame = 1'b0; nclk(1);
    chk("R6 req still low", req_n, 1'b0);
    seq_frame = 1'b1; seq_final = 1'b1; #1;
    chk("R5 ext ignored nonburst", req_n, 1'b1);
    nclk(1); seq_frame = 1'b0; seq_final = 1'b0;
    chk("R5 req stays released", req_n, 1'b1);
    finish_tenure();
  endtask

  task automatic t_burst_early();
    get_bus(1'b1, 1'b0);
    seq_frame = 1'b1; #1;
    chk("R5 burst frame drops req", req_n, 1'b1);
    nclk(1); seq_frame = 1'b0;
    chk("R8 no restart in tenure", seq_start, 1'b0);
    finish_tenure();
  endtask

  task automatic t_burst_extended();
    get_bus(1'b1, 1'b1);
    seq_frame = 1'b1; #1;
    chk("R7 frame keeps req", req_n, 1'b0);
    nclk(1); seq_frame = 1'b0; nclk(2);
    chk("R7 req held in data", req_n, 1'b0);
    seq_last_data = 1'b1; #1;
    chk("R7 drop at last data", req_n, 1'b1);
    nclk(1); seq_last_data = 1'b0;
    chk("R7 stays released", req_n, 1'b1);
    finish_tenure();
  endtask

  task automatic t_resets();
    dma_need = 1'b1; nclk(1);
    chk("R1 raised before soft reset", req_n, 1'b0);
    soft_rst = 1'b1; #1;
    chk("R10 soft reset immediate", req_n, 1'b1);
    dma_need = 1'b0; nclk(1); soft_rst = 1'b0; nclk(1);
    chk("R10 cleared after soft reset", req_n, 1'b1);
    dma_need = 1'b1; nclk(1);
    chk("R10 raise after soft reset", req_n, 1'b0);
    rst_n = 1'b0; #1;
    chk("R10 hw reset immediate", req_n, 1'b1);
    dma_need = 1'b0; nclk(1); rst_n = 1'b1; nclk(1);
    chk("R10 hw reset cleared", req_n, 1'b1);
  endtask

  initial begin
    forever begin
      @(posedge clk); cyc++;
      if (cyc > 20000) begin
        checks++; failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    t_reset();
    t_block_and_hold();
    t_grant_withdraw();
    t_nonburst_multi();
    t_burst_early();
    t_burst_extended();
    t_resets();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule